// File: doc/BRIEF.md
# Paired-Channel PWM Tick Divider

This block produces the count-enable ticks for two PWM channels that share one clock setting. It picks one of two reference pulse streams (an oscillator stream or a bus-clock stream), both given as single-cycle enable pulses in the system clock domain. It divides the chosen stream by a power of two and hands the result to each channel through that channel's own gate bit.

The shared setting holds a source-select field and a divider exponent M. It is written through `cfg_we` and can be read back on `src_q` and `exp_q`. Both channels use the same setting, so the block refuses a new setting while either channel's gate is open. A channel that is running can therefore never have its time base changed by a write meant for its partner. Software writes the setting first and opens the gates afterwards.

Top module: `pwm_pair_tick_div`

## Requirements
- R1: Synchronous active-low reset clears both gate bits, the divider counter, the stored source select and the stored exponent. In the cycle after reset is sampled low, `tick` is 2'b00, `src_q` is 0 and `exp_q` is 0.
- R2: With a stored source select of 0, only `osc_pulse` advances the divider, and pulses on `bus_pulse` produce no tick.
- R3: With a stored source select of 1, 2 or 3, only `bus_pulse` advances the divider, and pulses on `osc_pulse` produce no tick.
- R4: With M = 0, every selected source pulse gives a tick in the cycle after the edge that samples it.
- R5: With M from 1 to 8, the divider counts selected pulses from the last configuration write. The tick follows every 2^M-th pulse, with the same one-cycle latency as in R4, and the first tick follows pulse number 2^M.
- R6: A written exponent above 8 is stored as 8. `exp_q` then reads 8, and the divide ratio is 256.
- R7: An accepted configuration write clears the divider counter. A selected pulse in the same cycle as the write is dropped and gives no tick.
- R8: `tick[n]` carries the divided tick only while gate bit n (written from `gate_wdata[n]` when `gate_we` is high) is set. Both channels see the same divided tick.
- R9: A configuration write made while either gate bit is set is ignored. `src_q` and `exp_q` keep their values and the divider keeps counting.
- R10: When M is not 0, a tick lasts exactly one cycle and is never followed by a tick in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| osc_pulse | input | 1 | Oscillator reference enable pulse |
| bus_pulse | input | 1 | Bus-clock reference enable pulse |
| cfg_we | input | 1 | Write strobe for the shared setting |
| cfg_src | input | 2 | Source select; 0 selects the oscillator, any other value selects the bus clock |
| cfg_exp | input | 4 | Divider exponent M |
| gate_we | input | 1 | Write strobe for the gate bits |
| gate_wdata | input | 2 | New gate bits, bit n for channel n |
| tick | output | 2 | Gated count-enable tick, one bit per channel |
| src_q | output | 2 | Stored source select |
| exp_q | output | 4 | Stored exponent after clamping |

## Verification
The assertions assume that the reference pulses and the write strobes are known, 0 or 1, in every cycle after reset. A reference stream may be high in back-to-back cycles, and the divider must treat each of those cycles as a separate pulse. The stimulus changes every input only at the falling clock edge and writes the shared setting only with both gates closed. The one exception is the scenario that checks the lock, where a write is made on purpose with a gate open. Inside each scenario the pulses come on consecutive cycles, so the spacing between ticks can be counted exactly.

// File: rtl/pwm_pair_tick_div.sv
module pwm_pair_tick_div #(
  parameter int DIV_W = 8,
  parameter int EXP_W = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_pulse,
  input  logic             bus_pulse,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_src,
  input  logic [EXP_W-1:0] cfg_exp,
  input  logic             gate_we,
  input  logic [1:0]       gate_wdata,
  output logic [1:0]       tick,
  output logic [SEL_W-1:0] src_q,
  output logic [EXP_W-1:0] exp_q
);
  localparam int MW = DIV_W + 1;
  localparam logic [EXP_W-1:0] EXP_MAX = EXP_W'(DIV_W);
  localparam logic [MW-1:0] ONE_W = MW'(1);

  logic [SEL_W-1:0] src_r;
  logic [EXP_W-1:0] exp_r;
  logic [1:0]       gate_r;
  logic [DIV_W-1:0] cnt;
  logic             div_tick;

  wire             cfg_take    = cfg_we && (gate_r == 2'b00);
  wire [EXP_W-1:0] exp_clamped = (cfg_exp > EXP_MAX) ? EXP_MAX : cfg_exp;
  wire             sel_pulse   = (src_r == '0) ? osc_pulse : bus_pulse;
  wire [DIV_W-1:0] cnt_nxt     = cnt + DIV_W'(1);
  wire [MW-1:0]    mask_w      = (ONE_W << exp_r) - ONE_W;
  wire             wrap        = ((cnt_nxt & mask_w[DIV_W-1:0]) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_r    <= '0;
      exp_r    <= '0;
      gate_r   <= 2'b00;
      cnt      <= '0;
      div_tick <= 1'b0;
    end else begin
      if (gate_we) gate_r <= gate_wdata;
      if (cfg_take) begin
        src_r    <= cfg_src;
        exp_r    <= exp_clamped;
        cnt      <= '0;
        div_tick <= 1'b0;
      end else if (sel_pulse) begin
        cnt      <= cnt_nxt;
        div_tick <= wrap;
      end else begin
        div_tick <= 1'b0;
      end
    end
  end

  assign tick  = {2{div_tick}} & gate_r;
  assign src_q = src_r;
  assign exp_q = exp_r;

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    !rst_n |=> (tick == 2'b00 && src_q == '0 && exp_q == '0));

  // R2
  osc_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == '0 && !osc_pulse) |=> !div_tick);

  // R4
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_q == '0 && sel_pulse && !cfg_take) |=> div_tick);

  // R6
  exp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exp_q <= EXP_MAX);

  // R7
  cfg_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_take |=> !div_tick);

  // R9
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && gate_r != 2'b00) |=> ($stable(src_q) && $stable(exp_q)));

  // R10
  single_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_tick && exp_q != '0) |=> !div_tick);
endmodule

// File: tb/tb_pwm_pair_tick_div.sv
`timescale 1ns/1ps
module tb_pwm_pair_tick_div;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_pulse = 1'b0, bus_pulse = 1'b0, cfg_we = 1'b0, gate_we = 1'b0;
  logic [1:0] cfg_src = 2'b00, gate_wdata = 2'b00;
  logic [3:0] cfg_exp = 4'd0;
  logic [1:0] tick;
  logic [1:0] src_q;
  logic [3:0] exp_q;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_pair_tick_div dut (
    .clk(clk), .rst_n(rst_n), .osc_pulse(osc_pulse), .bus_pulse(bus_pulse),
    .cfg_we(cfg_we), .cfg_src(cfg_src), .cfg_exp(cfg_exp),
    .gate_we(gate_we), .gate_wdata(gate_wdata),
    .tick(tick), .src_q(src_q), .exp_q(exp_q));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(bit o, bit b, bit we = 0, logic [1:0] s = 0,
                     logic [3:0] e = 0, bit gw = 0, logic [1:0] gd = 0);
    @(negedge clk);
    osc_pulse = o; bus_pulse = b; cfg_we = we; cfg_src = s; cfg_exp = e;
    gate_we = gw; gate_wdata = gd;
    @(posedge clk);
    #1;
  endtask

  task automatic set_cfg(logic [1:0] s, logic [3:0] e);
    cyc(0, 0, 1, s, e);
  endtask

  task automatic set_gate(logic [1:0] g);
    cyc(0, 0, 0, 0, 0, 1, g);
  endtask

  task automatic run_pulses(int n, bit on_bus, output int cnt,
                            output int first, output bit dbl);
    bit prev = 0;
    cnt = 0; first = 0; dbl = 0;
    for (int i = 1; i <= n; i++) begin
      cyc(!on_bus, on_bus);
      if (tick[0]) begin
        cnt++;
        if (first == 0) first = i;
        if (prev) dbl = 1;
      end
      prev = tick[0];
    end
    cyc(0, 0);
  endtask

  task automatic t_reset();
    repeat (3) cyc(0, 0);
    rst_n = 1'b1;
    chk("R1 tick after reset", tick, 0);
    chk("R1 src_q after reset", src_q, 0);
    chk("R1 exp_q after reset", exp_q, 0);
  endtask

  task automatic t_osc();
    int c, f; bit d;
    set_cfg(0, 0);
    set_gate(2'b01);
    run_pulses(5, 1, c, f, d);
    chk("R2 bus pulses ignored with osc source", c, 0);
    run_pulses(5, 0, c, f, d);
    chk("R2 R4 osc pulses pass with M=0", c, 5);
    set_gate(2'b00);
  endtask

  task automatic t_bus();
    int c, f; bit d;
    for (int s = 1; s <= 3; s++) begin
      set_cfg(2'(s), 0);
      chk("R3 src_q readback", src_q, s);
      set_gate(2'b01);
      run_pulses(4, 0, c, f, d);
      chk("R3 osc pulses ignored with bus source", c, 0);
      run_pulses(4, 1, c, f, d);
      chk("R3 bus pulses counted", c, 4);
      set_gate(2'b00);
    end
  endtask

  task automatic t_div(int m);
    int c, f; bit d;
    set_cfg(0, 4'(m));
    chk("R5 exp_q readback", exp_q, m);
    set_gate(2'b01);
    run_pulses(2 << m, 0, c, f, d);
    chk("R5 tick count over two periods", c, 2);
    chk("R5 first tick position", f, 1 << m);
    chk("R10 no back-to-back ticks", d, 0);
    set_gate(2'b00);
  endtask

  task automatic t_clamp();
    int c, f; bit d;
    set_cfg(0, 4'd15);
    chk("R6 exponent clamped", exp_q, 8);
    set_gate(2'b01);
    run_pulses(512, 0, c, f, d);
    chk("R6 divide by 256 count", c, 2);
    chk("R6 first tick at 256", f, 256);
    set_gate(2'b00);
  endtask

  task automatic t_cnt_reset();
    int c, f; bit d;
    set_cfg(0, 4'd2);
    set_gate(2'b01);
    run_pulses(3, 0, c, f, d);
    chk("R7 no tick before 4 pulses", c, 0);
    set_gate(2'b00);
    cyc(1, 0, 1, 0, 4'd2);
    chk("R7 coincident pulse gives no tick", tick, 0);
    set_gate(2'b01);
    run_pulses(3, 0, c, f, d);
    chk("R7 counter cleared by write", c, 0);
    cyc(1, 0);
    chk("R7 tick on fourth pulse after write", tick, 1);
    set_gate(2'b00);
  endtask

  task automatic t_gate();
    set_cfg(0, 0);
    for (int g = 0; g < 4; g++) begin
      set_gate(2'(g));
      cyc(1, 0);
      chk("R8 tick follows gate bits", tick, g);
      cyc(0, 0);
      chk("R8 idle gives no tick", tick, 0);
    end
    set_gate(2'b00);
  endtask

  task automatic t_lock();
    int c, f; bit d;
    set_cfg(0, 0);
    set_gate(2'b10);
    set_cfg(1, 4'd5);
    chk("R9 src_q unchanged while gated", src_q, 0);
    chk("R9 exp_q unchanged while gated", exp_q, 0);
    cyc(1, 0);
    chk("R9 channel 1 keeps running", tick, 2);
    set_gate(2'b00);
    set_cfg(1, 4'd5);
    chk("R9 write accepted once gates closed", exp_q, 5);
    set_gate(2'b11);
    rst_n = 1'b0;
    cyc(0, 0);
    rst_n = 1'b1;
    cyc(1, 0);
    chk("R1 gates cleared by reset", tick, 0);
  endtask

  initial begin
    t_reset();
    t_osc();
    t_bus();
    t_div(1);
    t_div(3);
    t_div(8);
    t_clamp();
    t_cnt_reset();
    t_gate();
    t_lock();
    done = 1'b1;
  end

  initial begin
    int cycles = 0;
    while (!done && cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule